// File: doc/BRIEF.md
# Serial Receive DMA Engine

This block copies a run of bytes arriving from a serial shifter into system memory with no processor help. Software loads a destination address and a byte count, then writes a control word asking for a device-to-memory DMA. The engine takes bytes from the shifter one per handshake and packs them four to a 32-bit word, first byte in the most significant lane. It stores them in a small line buffer and writes each full 32-byte line to memory as one 8-beat burst on a valid/ready write master.

Address and count both move while the transfer runs: the address goes up by 32 and the count goes down by 32 each time a burst is accepted. The go bit in the control register reads 1 until the last burst has been accepted. Software polls that bit to learn the transfer is complete. Requests whose address or count is not a whole number of 32-byte lines are refused and set a sticky error flag.

Top module: `sdma_rx_engine`

## Requirements
- R1: After a synchronous reset the control, address and count registers read 0, `rx_ready` is 0 and `mem_valid` is 0.
- R2: Register offsets on `reg_addr` are 0x4 for the destination address and 0x8 for the byte count, and 0xC for control. A write while idle is visible on `reg_rdata` one cycle after `reg_addr` selects it.
- R3: Writing control (0xC) with bit 0 (go) = 1, bit 1 (DMA) = 1 and bits 3:2 (direction) = 00, while address and count are 32-byte aligned and the count is nonzero, starts a transfer. Control bit 0 (and bit 1) then read 1 and `rx_ready` goes high.
- R4: Bytes are packed big-endian: within each memory word the first byte received occupies bits 31:24 and the fourth occupies bits 7:0.
- R5: Each 32 received bytes produce exactly 8 write beats at `mem_addr` = current address register, with `mem_last` on the 8th beat only. Address, data and last are held while `mem_ready` is low.
- R6: `rx_ready` is 0 from the acceptance of the 32nd byte of a line until the 8th beat of its burst is accepted, so no byte of the next line enters early.
- R7: When a burst's last beat is accepted, the address register rises by 32 and the count falls by 32.
- R8: In the cycle after the final burst's last beat is accepted, control bit 0 reads 0 and `rx_ready` is 0.
- R9: A start request with a nonzero value in address bits 4:0 or count bits 4:0 sets control bit 8 (error), does not start and produces no memory traffic. The error stays set, even across later good transfers, until control is written with bit 8 = 1.
- R10: A control write with go = 1 but DMA = 0 or a nonzero direction starts nothing and leaves the error bit clear.
- R11: Writes to the address, count or control register during a transfer have no effect.
- R12: A start request with an aligned zero count starts nothing, sets no error and leaves control bit 0 at 0.
- R13: A 4096-byte transfer completes with 128 bursts, the address ending at start + 4096 and the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset within the channel |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| rx_valid | input | 1 | Serial shifter has a byte |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| mem_valid | output | 1 | Write beat valid |
| mem_addr | output | ADDR_W | Burst base address, 32-byte aligned |
| mem_data | output | DATA_W | Write beat data |
| mem_last | output | 1 | Final beat of the burst |
| mem_ready | input | 1 | Memory accepts the beat |

## Verification
A wrong byte counter or lane index shows up on the first burst, either as bytes in the wrong order within a word or as `mem_last` on the wrong beat. A broken hold flag lets `rx_ready` rise while a burst is still pending, which shows within one cycle of the 32nd byte. Stepping errors in the address or count show on the second burst's `mem_addr`, or as a go bit that clears one line early or late. Refusal and ignore paths leave no trace except in register readback and in a memory port that stays silent, so those are read back right after each request.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int REG_W = 32;
  localparam int OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_ADDR = 4'h4;
  localparam logic [OFS_W-1:0] OFS_LEN  = 4'h8;
  localparam logic [OFS_W-1:0] OFS_CTL  = 4'hC;

  localparam int CTL_GO     = 0;
  localparam int CTL_DMA    = 1;
  localparam int CTL_DIR_LO = 2;
  localparam int CTL_DIR_HI = 3;
  localparam int CTL_ERR    = 8;

  localparam logic [1:0] DIR_FROM_DEV = 2'b00;

  typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  reg_word_t         reg_wdata,
  output reg_word_t         reg_rdata,
  input  logic              line_done,
  output logic              run,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int ALIGN_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(LINE_BYTES);
  localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(LINE_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              run_q;
  logic              err_q;
  reg_word_t         rdata_q;
  reg_word_t         rd_mux;
  logic              go_req;
  logic              misaligned;

  assign go_req = reg_wdata[CTL_GO] && reg_wdata[CTL_DMA] &&
                  (reg_wdata[CTL_DIR_HI:CTL_DIR_LO] == DIR_FROM_DEV);
  assign misaligned = (|addr_q[ALIGN_W-1:0]) || (|len_q[ALIGN_W-1:0]);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_ADDR: rd_mux[ADDR_W-1:0] = addr_q;
      OFS_LEN:  rd_mux[LEN_W-1:0]  = len_q;
      OFS_CTL: begin
        rd_mux[CTL_GO]  = run_q;
        rd_mux[CTL_DMA] = run_q;
        rd_mux[CTL_ERR] = err_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      len_q   <= '0;
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_mux;
      if (run_q && line_done) begin
        addr_q <= addr_q + ADDR_STEP;
        len_q  <= len_q - LEN_STEP;
        if (len_q == LEN_STEP) run_q <= 1'b0;
      end
      if (reg_we && !run_q) begin
        case (reg_addr)
          OFS_ADDR: addr_q <= reg_wdata[ADDR_W-1:0];
          OFS_LEN:  len_q  <= reg_wdata[LEN_W-1:0];
          OFS_CTL: begin
            if (reg_wdata[CTL_ERR]) err_q <= 1'b0;
            if (go_req) begin
              if (misaligned)          err_q <= 1'b1;
              else if (len_q != '0)    run_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign run       = run_q;
  assign cur_addr  = addr_q;

  // R9: a refused request never coexists with a starting transfer
  p_err_no_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> !run_q);
endmodule

// File: rtl/sdma_packer.sv
module sdma_packer #(
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    line_done,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  output logic                    rx_ready,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [DATA_W-1:0]       wr_word,
  output logic                    line_full
);
  localparam int BPW     = DATA_W / 8;
  localparam int LANE_W  = $clog2(BPW);
  localparam int ALIGN_W = $clog2(LINE_BYTES);
  localparam int IDX_W   = ALIGN_W - LANE_W;

  logic [ALIGN_W-1:0] cnt_q;
  logic [DATA_W-1:0]  word_q;
  logic               hold_q;
  logic               full_q;
  logic               accept;
  logic               last_byte;
  logic [DATA_W-1:0]  word_next;

  assign rx_ready  = run && !hold_q;
  assign accept    = rx_ready && rx_valid;
  assign last_byte = (cnt_q == '1);
  assign word_next = {word_q[DATA_W-9:0], rx_byte};

  assign wr_en   = accept && (cnt_q[LANE_W-1:0] == '1);
  assign wr_idx  = cnt_q[ALIGN_W-1:LANE_W];
  assign wr_word = word_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      word_q <= '0;
      hold_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      full_q <= accept && last_byte;
      if (accept) begin
        cnt_q  <= cnt_q + 1'b1;
        word_q <= word_next;
      end
      if (!run)                     hold_q <= 1'b0;
      else if (accept && last_byte) hold_q <= 1'b1;
      else if (line_done)           hold_q <= 1'b0;
    end
  end

  assign line_full = full_q;
endmodule

// File: rtl/sdma_linebuf.sv
module sdma_linebuf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/sdma_burst.sv
module sdma_burst #(
  parameter int BEATS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     line_full,
  input  logic                     mem_ready,
  output logic                     rd_en,
  output logic [$clog2(BEATS)-1:0] rd_idx,
  output logic                     mem_valid,
  output logic                     mem_last,
  output logic                     line_done
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] PENULT = BEAT_W'(BEATS - 2);

  logic              valid_q;
  logic              last_q;
  logic [BEAT_W-1:0] beat_q;
  logic              fire;

  assign fire      = valid_q && mem_ready;
  assign line_done = fire && last_q;
  assign rd_en     = line_full || (fire && !last_q);
  assign rd_idx    = line_full ? '0 : beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      beat_q  <= '0;
    end else if (line_full) begin
      valid_q <= 1'b1;
      last_q  <= (BEATS == 1);
      beat_q  <= '0;
    end else if (fire) begin
      if (last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else begin
        beat_q <= beat_q + 1'b1;
        last_q <= (beat_q == PENULT);
      end
    end
  end

  assign mem_valid = valid_q;
  assign mem_last  = last_q;

  // R6: the packer can only finish a line while no burst is in flight
  p_full_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    line_full |-> !valid_q);
endmodule

// File: rtl/sdma_rx_engine.sv
module sdma_rx_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_last,
  input  logic              mem_ready
);
  localparam int BPW     = DATA_W / 8;
  localparam int BEATS   = LINE_BYTES / BPW;
  localparam int IDX_W   = $clog2(BEATS);
  localparam int ALIGN_W = $clog2(LINE_BYTES);

  logic              run;
  logic              line_done;
  logic              line_full;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_word;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;

  sdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_done(line_done),
    .run(run), .cur_addr(mem_addr)
  );

  sdma_packer #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) u_packer (
    .clk(clk), .rst(rst), .run(run), .line_done(line_done),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .line_full(line_full)
  );

  sdma_linebuf #(.DATA_W(DATA_W), .DEPTH(BEATS)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_word),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(mem_data)
  );

  sdma_burst #(.BEATS(BEATS)) u_burst (
    .clk(clk), .rst(rst), .line_full(line_full), .mem_ready(mem_ready),
    .rd_en(rd_en), .rd_idx(rd_idx), .mem_valid(mem_valid),
    .mem_last(mem_last), .line_done(line_done)
  );

  // R6: the shifter is back-pressured while a burst is outstanding
  p_stall_rx_r6: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !rx_ready);

  // R5: bursts start on line boundaries
  p_addr_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[ALIGN_W-1:0] == '0));

  // R5: a beat that is not taken stays unchanged
  p_beat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_data) && $stable(mem_addr) && $stable(mem_last)));

  // R8: the transfer ends only on acceptance of a final beat
  p_end_on_last_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past(mem_valid && mem_ready && mem_last));
endmodule

// File: tb/sdma_rx_engine_bench.sv
module sdma_rx_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h0;
  logic        rx_ready;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_last;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit timeout = 1'b0;

  always #4 clk = ~clk;

  sdma_rx_engine u_sdma_rx_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_ready(rx_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_last(mem_last),
    .mem_ready(mem_ready)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic [3:0]  ctl;
    logic [7:0]  seed;
    logic        stall;
    logic        exp_run;
    logic        exp_err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 16'd32, 4'h3, 8'h11, 1'b0, 1'b1, 1'b0},
    '{32'h0000_2040, 16'd96, 4'h3, 8'h5A, 1'b1, 1'b1, 1'b0},
    '{32'h0000_3004, 16'd32, 4'h3, 8'h00, 1'b0, 1'b0, 1'b1},
    '{32'h0000_3000, 16'd40, 4'h3, 8'h00, 1'b0, 1'b0, 1'b1},
    '{32'h0000_4000, 16'd64, 4'h1, 8'h00, 1'b0, 1'b0, 1'b0},
    '{32'h0000_4000, 16'd64, 4'h7, 8'h00, 1'b0, 1'b0, 1'b0},
    '{32'h0000_4000, 16'd0,  4'h3, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [7:0] bval(input logic [7:0] seed, input int k);
    bval = seed + 8'(k * 7);
  endfunction

  // Feeds bytes and accepts beats from beat first_b up to beat last_b (exclusive).
  task automatic stream(input logic [31:0] base, input int len, input logic [7:0] seed,
                        input bit stall, input int first_b, input int last_b);
    int sent = first_b * 4;
    int beats = first_b;
    int cyc = 0;
    int bad6 = 0;
    while (beats < last_b && !timeout) begin
      @(negedge clk);
      cyc++;
      if (mem_valid && rx_ready) bad6++;
      if (rx_ready && sent == (beats / 8 + 1) * 32) bad6++;
      if (rx_ready && sent < len) begin
        rx_valid = 1'b1; rx_byte = bval(seed, sent); sent++;
      end else begin
        rx_valid = 1'b0;
      end
      mem_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (mem_valid && mem_ready) begin
        check("R4", "word", mem_data,
              {bval(seed, beats*4), bval(seed, beats*4+1),
               bval(seed, beats*4+2), bval(seed, beats*4+3)});
        check("R5", "addr", mem_addr, base + 32'((beats / 8) * 32));
        check("R5", "last", {31'b0, mem_last}, {31'b0, (beats % 8) == 7});
        beats++;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; mem_ready = 1'b0;
    check("R6", "early byte or ready during burst", bad6, 0);
  endtask

  task automatic idle_watch(input string req);
    int seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mem_valid || rx_ready) seen++;
    end
    check(req, "no traffic", seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    timeout = 1'b1;
    fails++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1", "rx_ready", {31'b0, rx_ready}, 0);
    check("R1", "mem_valid", {31'b0, mem_valid}, 0);
    rd(4'hC, v); check("R1", "ctl", v, 0);
    rd(4'h4, v); check("R1", "addr", v, 0);
    rd(4'h8, v); check("R1", "len", v, 0);

    wr(4'h4, 32'h1234_5660); rd(4'h4, v); check("R2", "addr rb", v, 32'h1234_5660);
    wr(4'h8, 32'h0000_0140); rd(4'h8, v); check("R2", "len rb", v, 32'h0000_0140);

    for (int i = 0; i < NV; i++) begin
      vec_t t = VECS[i];
      wr(4'h4, t.addr);
      wr(4'h8, {16'b0, t.len});
      wr(4'hC, {28'b0, t.ctl});
      rd(4'hC, v);
      check(t.exp_run ? "R3" : (t.exp_err ? "R9" : "R10/R12 R10 R12"),
            "go bit", {31'b0, v[0]}, {31'b0, t.exp_run});
      check("R9", "err bit", {31'b0, v[8]}, {31'b0, t.exp_err});
      if (t.exp_run) begin
        check("R3", "rx_ready", {31'b0, rx_ready}, 1);
        stream(t.addr, int'(t.len), t.seed, t.stall, 0, int'(t.len) / 4);
        check("R8", "rx_ready after end", {31'b0, rx_ready}, 0);
        rd(4'hC, v); check("R8", "go cleared", {31'b0, v[0]}, 0);
        rd(4'h4, v); check("R7", "final addr", v, t.addr + {16'b0, t.len});
        rd(4'h8, v); check("R7", "final len", v, 0);
      end else begin
        idle_watch(t.exp_err ? "R9" : "R10");
      end
      wr(4'hC, 32'h100);
      rd(4'hC, v); check("R9", "err cleared", v, 0);
    end

    // R12 zero count explicitly
    wr(4'h4, 32'h0000_4400); wr(4'h8, 32'h0); wr(4'hC, 32'h3);
    rd(4'hC, v); check("R12", "zero count ctl", v, 0);

    // R9 sticky across a good transfer
    wr(4'h4, 32'h0000_5010); wr(4'h8, 32'd32); wr(4'hC, 32'h3);
    rd(4'hC, v); check("R9", "err set", v, 32'h100);
    wr(4'h4, 32'h0000_5000); wr(4'hC, 32'h3);
    stream(32'h0000_5000, 32, 8'h33, 1'b0, 0, 8);
    rd(4'hC, v); check("R9", "err sticky", v, 32'h100);
    wr(4'hC, 32'h100); rd(4'hC, v); check("R9", "err w1c", v, 0);

    // R11 writes ignored while busy, R7 mid-transfer progress
    wr(4'h4, 32'h0000_6000); wr(4'h8, 32'd64); wr(4'hC, 32'h3);
    wr(4'h4, 32'h0000_7000); wr(4'h8, 32'h20); wr(4'hC, 32'h100);
    rd(4'h4, v); check("R11", "addr kept", v, 32'h0000_6000);
    rd(4'h8, v); check("R11", "len kept", v, 32'd64);
    rd(4'hC, v); check("R11", "ctl kept", v, 32'h3);
    stream(32'h0000_6000, 64, 8'hC4, 1'b1, 0, 8);
    check("R6", "ready released", {31'b0, rx_ready}, 1);
    rd(4'h4, v); check("R7", "addr +32", v, 32'h0000_6020);
    rd(4'h8, v); check("R7", "len -32", v, 32'd32);
    stream(32'h0000_6000, 64, 8'hC4, 1'b1, 8, 16);
    rd(4'hC, v); check("R8", "go cleared", v, 0);

    // R13 full 4096-byte transfer with stalls
    wr(4'h4, 32'h0000_8000); wr(4'h8, 32'd4096); wr(4'hC, 32'h3);
    stream(32'h0000_8000, 4096, 8'h7E, 1'b1, 0, 1024);
    rd(4'hC, v); check("R13", "go cleared", v, 0);
    rd(4'h4, v); check("R13", "end addr", v, 32'h0000_9000);
    rd(4'h8, v); check("R13", "end len", v, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule